// File: doc/BRIEF.md
# Frame-Boundary Alignment Character Substituter

This block sits in the transmit path of a serial converter link during the data phase. Each clock it takes one user octet with two position strobes, one marking the last octet of a frame and one marking the last octet of a multiframe. One cycle later it puts out that octet, or an alignment control character in its place, with a flag that marks control characters for the line encoder downstream. The receiver sees these characters at known positions, so it can keep checking that frame and multiframe alignment have not moved since link start-up. The substituted character takes the slot of the octet it replaces, so the data rate does not change.

When scrambling is off, a final octet is substituted when it matches the final octet of the frame before it. When scrambling is on, substitution depends on the octet value alone. A multiframe end may be marked with or without the frame-end strobe, and it always counts as a frame end too. Scrambling and line coding are done by other blocks.

Top module: `align_char_sub`

## Requirements
- R1: While reset is held and in the first cycle after it, `oct_out` is 0x00 and `is_ctrl` is 0.
- R2: Every input octet appears on the output exactly one clock later. An octet with neither strobe set is passed unchanged with `is_ctrl` = 0, even when it equals an earlier final octet.
- R3: With `scramble_on` = 0, a frame-final octet with `mframe_end` = 0 that equals the previous frame's final octet comes out as 0xFC with `is_ctrl` = 1.
- R4: With `scramble_on` = 0, a multiframe-final octet that equals the previous frame's final octet comes out as 0x7C with `is_ctrl` = 1.
- R5: With `scramble_on` = 0, a final octet that differs from the previous frame's final octet is passed unchanged with `is_ctrl` = 0. The first frame end after reset has no predecessor and is never substituted.
- R6: The reference for the comparison is the original input octet of the last frame end in either scramble mode, never the substituted character. Three equal final octets in a row are therefore the original value, then 0xFC, then 0xFC.
- R7: With `scramble_on` = 1, a multiframe-final octet equal to 0x7C comes out as 0x7C with `is_ctrl` = 1. Any other multiframe-final value, 0xFC included, is passed with `is_ctrl` = 0.
- R8: With `scramble_on` = 1, a frame-final octet with `mframe_end` = 0 equal to 0xFC comes out as 0xFC with `is_ctrl` = 1. Any other value, 0x7C included, is passed with `is_ctrl` = 0.
- R9: With `scramble_on` = 1, a match with the previous frame's final octet has no effect: such an octet is passed with `is_ctrl` = 0 unless R7 or R8 applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one octet per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| oct_in | input | 8 | User octet |
| frame_end | input | 1 | Marks the last octet of a frame |
| mframe_end | input | 1 | Marks the last octet of a multiframe (implies a frame end) |
| scramble_on | input | 1 | Scrambling enabled; selects the substitution rule |
| oct_out | output | 8 | Output octet, one cycle after input |
| is_ctrl | output | 1 | Set when `oct_out` is a substituted control character |

## Verification
The assertions read `scramble_on` in the same cycle as the octet it governs. They take the setting as belonging to that octet and expect the strobes to be clean, known values on every clock. The stimulus changes the scramble setting only at interior octets between frames and raises each strobe for exactly one octet. Because the reference is kept across mode changes, the frame boundaries around a mode switch still give expected values the bench can predict.

// File: rtl/align_char_sub.sv
module align_char_sub #(
  parameter int OCT_W = 8,
  parameter logic [OCT_W-1:0] A_CHAR = 'h7C,
  parameter logic [OCT_W-1:0] F_CHAR = 'hFC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OCT_W-1:0] oct_in,
  input  logic             frame_end,
  input  logic             mframe_end,
  input  logic             scramble_on,
  output logic [OCT_W-1:0] oct_out,
  output logic             is_ctrl
);

  logic [OCT_W-1:0] ref_oct;
  logic             ref_ok;

  logic             fin, hit_scr, hit_plain, swap;
  logic [OCT_W-1:0] sub_char;

  assign fin       = frame_end | mframe_end;
  assign hit_scr   = mframe_end ? (oct_in == A_CHAR) : (oct_in == F_CHAR);
  assign hit_plain = ref_ok && (oct_in == ref_oct);
  assign swap      = fin && (scramble_on ? hit_scr : hit_plain);
  assign sub_char  = mframe_end ? A_CHAR : F_CHAR;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      oct_out <= '0;
      is_ctrl <= 1'b0;
      ref_oct <= '0;
      ref_ok  <= 1'b0;
    end else begin
      oct_out <= swap ? sub_char : oct_in;
      is_ctrl <= swap;
      if (fin) begin
        ref_oct <= oct_in;
        ref_ok  <= 1'b1;
      end
    end
  end

  // R2: interior octets pass through after one cycle
  a_r2_interior_pass: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_end || mframe_end) |=> (oct_out == $past(oct_in)) && !is_ctrl);

  // R2: a control flag only follows a final octet
  a_r2_ctrl_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    is_ctrl |-> $past(frame_end || mframe_end));

  // R7
  a_r7_scr_mframe: assert property (@(posedge clk) disable iff (!rst_n)
    (scramble_on && mframe_end && oct_in == A_CHAR) |=> is_ctrl && oct_out == A_CHAR);

  // R8
  a_r8_scr_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (scramble_on && frame_end && !mframe_end && oct_in == F_CHAR) |=> is_ctrl && oct_out == F_CHAR);

  // R9: in scrambled mode, other values are never substituted
  a_r9_scr_other: assert property (@(posedge clk) disable iff (!rst_n)
    (scramble_on && mframe_end && oct_in != A_CHAR) |=> !is_ctrl && oct_out == $past(oct_in));

  // R3: substituted output is always an alignment character
  a_r3_ctrl_value: assert property (@(posedge clk) disable iff (!rst_n)
    is_ctrl |-> (oct_out == A_CHAR || oct_out == F_CHAR));

endmodule

// File: tb/align_char_sub_bench.sv
`timescale 1ns/100ps
module align_char_sub_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] oct_in = 8'h00;
  logic       frame_end = 1'b0, mframe_end = 1'b0, scramble_on = 1'b0;
  logic [7:0] oct_out;
  logic       is_ctrl;

  int errors = 0, checks = 0;
  logic [8:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] m_ref;
  logic       m_ok;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  align_char_sub u_align_char_sub (
    .clk(clk), .rst_n(rst_n), .oct_in(oct_in), .frame_end(frame_end),
    .mframe_end(mframe_end), .scramble_on(scramble_on),
    .oct_out(oct_out), .is_ctrl(is_ctrl));

  task automatic check(string tag, logic [7:0] d, logic c, logic [7:0] ed, logic ec);
    checks++;
    if (d !== ed || c !== ec) begin
      errors++;
      $display("FAIL %s: got oct=%h ctrl=%b expected oct=%h ctrl=%b", tag, d, c, ed, ec);
    end
  endtask

  task automatic send(logic [7:0] d, logic fe, logic me, string tag);
    logic rep;
    logic [7:0] ed;
    @(negedge clk);
    oct_in = d; frame_end = fe; mframe_end = me;
    rep = 1'b0;
    if (fe || me) begin
      if (scramble_on) rep = me ? (d == 8'h7C) : (d == 8'hFC);
      else             rep = m_ok && (d == m_ref);
      m_ref = d; m_ok = 1'b1;
    end
    ed = rep ? (me ? 8'h7C : 8'hFC) : d;
    exp_q.push_back({rep, ed});
    tag_q.push_back(tag);
  endtask

  task automatic idle(logic scr);
    @(negedge clk);
    frame_end = 1'b0; mframe_end = 1'b0; scramble_on = scr; oct_in = 8'h00;
  endtask

  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      logic [8:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, oct_out, is_ctrl, e[7:0], e[8]);
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got running expected finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    m_ref = 8'h00; m_ok = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 during reset", oct_out, is_ctrl, 8'h00, 1'b0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 after reset", oct_out, is_ctrl, 8'h00, 1'b0);

    // plain mode
    send(8'h11, 0, 0, "R2 interior");
    send(8'h22, 0, 0, "R2 interior");
    send(8'h55, 1, 0, "R5 first frame end");
    send(8'h55, 0, 0, "R2 interior equal to ref");
    send(8'h33, 0, 0, "R2 interior");
    send(8'h55, 1, 0, "R3 equal frame end");
    send(8'h01, 0, 0, "R2 interior");
    send(8'h55, 1, 0, "R6 ref is original");
    send(8'h12, 1, 0, "R5 differing frame end");
    send(8'h12, 1, 1, "R4 equal multiframe end");
    send(8'hFC, 1, 0, "R5 differing FC");
    send(8'h7C, 0, 1, "R5 differing 7C mframe");
    send(8'h7C, 0, 1, "R4 mframe strobe alone");
    // scrambled mode
    idle(1'b1);
    send(8'h7C, 1, 1, "R7 mframe 7C");
    send(8'hFC, 1, 1, "R7 mframe FC passes");
    send(8'hFC, 1, 0, "R8 frame FC");
    send(8'h7C, 1, 0, "R8 frame 7C passes");
    send(8'h44, 1, 0, "R9 setup");
    send(8'h44, 1, 0, "R9 equal ignored");
    send(8'h44, 1, 1, "R9 equal mframe ignored");
    send(8'hFC, 1, 0, "R8 frame FC again");
    // back to plain: reference kept from scrambled frame end
    idle(1'b0);
    send(8'hFC, 1, 0, "R6 ref across modes");
    send(8'h90, 0, 0, "R2 interior");
    idle(1'b0);
    idle(1'b0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule